// File: doc/BRIEF.md
# DRAM Identity Readout Responder

This block is the identification-readout part of a graphics DRAM device model. It samples the decoded command pins (chip select, row strobe, column strobe, write enable, bank address and address) on each rising clock edge. An extended mode register set command with the identity address bit high arms an identity readout. After a programmable number of cycles, the lower byte of the data bus shows a fixed manufacturer code in its low nibble and a revision code in its high nibble. The value stays on the bus until an extended mode register set with the identity bit low arrives. A second programmable delay later, the bus returns to all ones.

While the readout is pending or active, the only commands allowed are NOP, deselect and the extended mode register set. Any other command raises a sticky protocol-error flag. The command pins are plain per-cycle inputs with no handshake, because the device cannot push back on its controller. The data outputs are likewise a plain level and enable pair.

Top module: `idr_top`

## Requirements
- R1: While `rst` is high at a rising edge, `dq_oe` is low after that edge and `proto_err` is cleared. After the first edge with `rst` low, `dq_oe` is high from then on.
- R2: In the idle state, `dq_out` is 8'hFF with `dq_oe` high.
- R3: While identity data is shown, `dq_out[3:0]` is 4'b0010 and `dq_out[7:4]` is the `REV_ID` parameter.
- R4: The enable command is an extended mode register set: `cs_n`, `ras_n`, `cas_n` and `we_n` all low, `ba` = 2'b01, with `addr[10]` = 1. If it is sampled at edge k from idle, `dq_out` stays 8'hFF up to and including edge k+T_ON_CYC-1, and shows the identity value from edge k+T_ON_CYC.
- R5: During the turn-on wait, a further enable command restarts the full T_ON_CYC count. A disable command (the same encoding with `addr[10]` = 0) returns the block to idle, and the bus stays 8'hFF.
- R6: A disable command sampled at edge k while identity data is shown keeps the identity value through edge k+T_OFF_CYC-1. From edge k+T_OFF_CYC, `dq_out` is 8'hFF.
- R7: During the turn-off wait, a further disable command restarts the full T_OFF_CYC count. An enable command returns the block to identity drive, with no gap on the bus.
- R8: Any command with `cs_n` low that is neither NOP (`ras_n`,`cas_n`,`we_n` = 1,1,1) nor an extended mode register set sets `proto_err` at the next edge if it arrives during the turn-on wait or identity drive. Such a command does not alter the bus sequence. A plain mode register set (`ba` = 2'b00) counts as such a command.
- R9: `proto_err` stays set until reset. Illegal commands in idle or in the turn-off wait do not set it.
- R10: Address bits other than bit 10 have no effect. A cycle with `cs_n` high is ignored whatever the other pins are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address; 2'b01 selects the extended mode register |
| addr | input | ADDR_W | Address; bit ID_BIT arms or clears the identity readout |
| dq_out | output | 8 | Data bus drive value |
| dq_oe | output | 1 | Data bus drive enable |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
A wrong state or counter value shows at `dq_out` as early or late identity data. A miscount in the turn-on or turn-off wait moves the switching edge by at least one cycle, so the bus value sampled after each edge exposes it in that same cycle. A state that is wrongly treated as guarded, or not guarded, shows one edge after an illegal command, as a `proto_err` that rises when it should not or stays low when it should rise. Random command streams with varying address bits check each edge against a cycle model and cover the restarts and cancellations.

// File: rtl/idr_pkg.sv
package idr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ON_WAIT  = 2'd1,
    ST_DRIVE    = 2'd2,
    ST_OFF_WAIT = 2'd3
  } idr_state_e;

  typedef struct packed {
    logic quiet;    // deselect or NOP
    logic id_set;   // extended MRS, identity bit high
    logic id_clr;   // extended MRS, identity bit low
    logic illegal;  // any other selected command
  } idr_cmd_t;

  localparam logic [3:0] MFR_CODE  = 4'b0010;
  localparam logic [7:0] BUS_IDLE  = 8'hFF;
  localparam logic [1:0] BA_EXT_MR = 2'b01;

endpackage

// File: rtl/idr_cmd_decode.sv
module idr_cmd_decode
  import idr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned ID_BIT = 10
) (
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output idr_cmd_t          cmd
);

  logic is_nop;
  logic is_ext_mr;

  always_comb begin
    is_nop      = cs_n || (ras_n && cas_n && we_n);
    is_ext_mr   = !cs_n && !ras_n && !cas_n && !we_n && (ba == BA_EXT_MR);
    cmd.quiet   = is_nop;
    cmd.id_set  = is_ext_mr && addr[ID_BIT];
    cmd.id_clr  = is_ext_mr && !addr[ID_BIT];
    cmd.illegal = !is_nop && !is_ext_mr;
  end

endmodule

// File: rtl/idr_delay_cnt.sv
module idr_delay_cnt #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);

  localparam int unsigned CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] RELOAD = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= RELOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/idr_fsm.sv
module idr_fsm
  import idr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  idr_cmd_t   cmd,
  input  logic       on_done,
  input  logic       off_done,
  output idr_state_e state,
  output logic       on_load,
  output logic       off_load,
  output logic       viol
);

  idr_state_e state_q, state_d;
  logic       viol_q;
  logic       guarded;

  always_comb begin
    state_d  = state_q;
    on_load  = 1'b0;
    off_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd.id_set) begin
          state_d = ST_ON_WAIT;
          on_load = 1'b1;
        end
      end
      ST_ON_WAIT: begin
        if (cmd.id_set)      on_load = 1'b1;
        else if (cmd.id_clr) state_d = ST_IDLE;
        else if (on_done)    state_d = ST_DRIVE;
      end
      ST_DRIVE: begin
        if (cmd.id_clr) begin
          state_d  = ST_OFF_WAIT;
          off_load = 1'b1;
        end
      end
      ST_OFF_WAIT: begin
        if (cmd.id_set)      state_d  = ST_DRIVE;
        else if (cmd.id_clr) off_load = 1'b1;
        else if (off_done)   state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign guarded = (state_q == ST_ON_WAIT) || (state_q == ST_DRIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      viol_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      viol_q  <= viol_q || (guarded && cmd.illegal);
    end
  end

  assign state = state_q;
  assign viol  = viol_q;

endmodule

// File: rtl/idr_dq_drive.sv
module idr_dq_drive
  import idr_pkg::*;
#(
  parameter logic [3:0] REV_ID = 4'h0
) (
  input  logic       clk,
  input  logic       rst,
  input  idr_state_e state,
  output logic [7:0] dq_out,
  output logic       dq_oe
);

  localparam logic [7:0] ID_WORD = {REV_ID, MFR_CODE};

  logic oe_q;

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= 1'b1;
  end

  always_comb begin
    if (state == ST_DRIVE || state == ST_OFF_WAIT) dq_out = ID_WORD;
    else                                           dq_out = BUS_IDLE;
  end

  assign dq_oe = oe_q;

endmodule

// File: rtl/idr_top.sv
module idr_top
  import idr_pkg::*;
#(
  parameter int unsigned T_ON_CYC  = 4,
  parameter int unsigned T_OFF_CYC = 3,
  parameter logic [3:0]  REV_ID    = 4'h0,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned ID_BIT    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              proto_err
);

  idr_cmd_t   cmd;
  idr_state_e state;
  logic       on_load, off_load, on_done, off_done;

  idr_cmd_decode #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cmd(cmd)
  );

  idr_delay_cnt #(.DELAY(T_ON_CYC)) u_on_cnt (
    .clk(clk), .rst(rst), .load(on_load), .done(on_done)
  );

  idr_delay_cnt #(.DELAY(T_OFF_CYC)) u_off_cnt (
    .clk(clk), .rst(rst), .load(off_load), .done(off_done)
  );

  idr_fsm u_fsm (
    .clk(clk), .rst(rst), .cmd(cmd), .on_done(on_done), .off_done(off_done),
    .state(state), .on_load(on_load), .off_load(off_load), .viol(proto_err)
  );

  idr_dq_drive #(.REV_ID(REV_ID)) u_drv (
    .clk(clk), .rst(rst), .state(state), .dq_out(dq_out), .dq_oe(dq_oe)
  );

endmodule

// File: rtl/idr_checker.sv
module idr_checker
  import idr_pkg::*;
#(
  parameter logic [3:0] REV_ID = 4'h0
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic       id_bit,
  input logic [7:0] dq_out,
  input logic       dq_oe,
  input logic       proto_err,
  input logic [1:0] state
);

  localparam logic [7:0] ID_WORD = {REV_ID, MFR_CODE};

  logic ext_mr, bad_cmd, guarded;
  assign ext_mr  = !cs_n && !ras_n && !cas_n && !we_n && (ba == BA_EXT_MR);
  assign bad_cmd = !cs_n && !(ras_n && cas_n && we_n) && !ext_mr;
  assign guarded = (state == ST_ON_WAIT) || (state == ST_DRIVE);

  AST_OE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> dq_oe) else $error("oe low after reset"); // R1

  AST_ID_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && dq_out != BUS_IDLE) |-> (dq_out == ID_WORD)) else $error("bad id word"); // R3

  AST_ON_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && ext_mr && id_bit) |=> (dq_out == BUS_IDLE)) else $error("id early"); // R4

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRIVE && ext_mr && !id_bit) |=> (dq_out == ID_WORD)) else $error("id dropped early"); // R6

  AST_VIOL_SET: assert property (@(posedge clk) disable iff (rst)
    (guarded && bad_cmd) |=> proto_err) else $error("violation missed"); // R8

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err) else $error("violation cleared"); // R9

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cs_n && state == ST_IDLE) |=> (state == ST_IDLE && dq_out == BUS_IDLE)) else $error("deselect acted"); // R10

endmodule

bind idr_top idr_checker #(.REV_ID(REV_ID)) u_idr_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .id_bit(addr[ID_BIT]), .dq_out(dq_out), .dq_oe(dq_oe),
  .proto_err(proto_err), .state(state)
);

// File: tb/idr_top_bench.sv
`timescale 1ns/1ps
module idr_top_bench;

  localparam int unsigned T_ON  = 4;
  localparam int unsigned T_OFF = 3;
  localparam logic [3:0]  REV   = 4'h5;
  localparam logic [7:0]  IDW   = {REV, 4'b0010};

  // command kinds
  localparam int K_DESEL = 0, K_NOP = 1, K_SET = 2, K_CLR = 3, K_READ = 4, K_MRS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'b00;
  logic [11:0] addr = '0;
  logic [7:0]  dq_out;
  logic        dq_oe, proto_err;

  int checks = 0;
  int failures = 0;

  // reference model
  int m_st = 0;   // 0 idle, 1 on wait, 2 drive, 3 off wait
  int m_cnt = 0;
  bit m_err = 1'b0;

  always #10 clk = ~clk;

  idr_top #(.T_ON_CYC(T_ON), .T_OFF_CYC(T_OFF), .REV_ID(REV)) u_idr_top (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe), .proto_err(proto_err)
  );

  function automatic logic [7:0] exp_dq(input int st);
    return (st == 2 || st == 3) ? IDW : 8'hFF;
  endfunction

  function automatic string st_req(input int st);
    case (st)
      0: return "R2";
      1: return "R4";
      2: return "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic check_bit(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string ctx);
    checks++;
    if (dq_out !== exp_dq(m_st)) begin
      failures++;
      $display("FAIL %s (%s) dq_out: actual=%h expected=%h", st_req(m_st), ctx, dq_out, exp_dq(m_st));
    end
    check_bit(dq_oe, 1'b1, "R1", "dq_oe");
    check_bit(proto_err, m_err, m_err ? "R8" : "R9", "proto_err");
  endtask

  task automatic model_update(input int kind);
    bit illegal = (kind == K_READ || kind == K_MRS);
    if (illegal && (m_st == 1 || m_st == 2)) m_err = 1'b1;
    case (m_st)
      0: if (kind == K_SET) begin m_st = 1; m_cnt = T_ON - 1; end
      1: begin
        if (kind == K_SET)      m_cnt = T_ON - 1;
        else if (kind == K_CLR) m_st = 0;
        else if (m_cnt == 0)    m_st = 2;
        else                    m_cnt--;
      end
      2: if (kind == K_CLR) begin m_st = 3; m_cnt = T_OFF - 1; end
      default: begin
        if (kind == K_SET)      m_st = 2;
        else if (kind == K_CLR) m_cnt = T_OFF - 1;
        else if (m_cnt == 0)    m_st = 0;
        else                    m_cnt--;
      end
    endcase
  endtask

  // check outputs from previous edges, then drive one command for the next edge
  task automatic step(input int kind, input logic [11:0] a, input string ctx);
    @(negedge clk);
    check_outputs(ctx);
    addr = a;
    ba   = 2'b00;
    case (kind)
      K_DESEL: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'($urandom); ba = 2'b01; end
      K_NOP:   begin cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111; end
      K_SET:   begin cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b000; ba = 2'b01; addr[10] = 1'b1; end
      K_CLR:   begin cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b000; ba = 2'b01; addr[10] = 1'b0; end
      K_READ:  begin cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b101; end
      default: begin cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b000; ba = 2'b00; end
    endcase
    model_update(kind);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check_bit(dq_oe, 1'b0, "R1", "dq_oe during reset");
    check_bit(proto_err, 1'b0, "R1", "proto_err during reset");
    rst = 1'b0;
    m_st = 0; m_cnt = 0; m_err = 1'b0;
  endtask

  task automatic idle_steps(input int n, input string ctx);
    for (int i = 0; i < n; i++) step(K_NOP, 12'($urandom), ctx);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4077));
    do_reset();
    idle_steps(2, "R2 idle after reset");

    // R4 basic turn-on, R6 basic turn-off
    step(K_SET, 12'h000, "R4 enable");
    idle_steps(T_ON + 2, "R4 wait");
    step(K_CLR, 12'hBFF, "R6 disable");
    idle_steps(T_OFF + 2, "R6 wait");

    // R5 restart and abort in turn-on wait
    step(K_SET, 12'h400, "R5 enable");
    idle_steps(T_ON - 2, "R5 partial");
    step(K_SET, 12'h7FF, "R5 restart");
    idle_steps(T_ON - 1, "R5 after restart");
    step(K_CLR, 12'h3FF, "R5 abort");
    idle_steps(T_ON + 1, "R5 idle after abort");

    // R7 restart and cancel in turn-off wait
    step(K_SET, 12'h400, "R7 enable");
    idle_steps(T_ON, "R7 drive");
    step(K_CLR, 12'h000, "R7 disable");
    idle_steps(T_OFF - 2, "R7 partial");
    step(K_CLR, 12'h123, "R7 restart");
    idle_steps(T_OFF - 1, "R7 after restart");
    step(K_SET, 12'h400, "R7 cancel");
    idle_steps(2, "R7 back to drive");
    step(K_CLR, 12'h000, "R7 disable again");
    step(K_READ, 12'h000, "R9 read in off wait");
    step(K_MRS, 12'h000, "R9 mrs in off wait");
    idle_steps(T_OFF + 1, "R9 no error");
    step(K_READ, 12'h000, "R9 read in idle");
    idle_steps(2, "R9 idle");

    // R10 random legal traffic; illegal only where it must be ignored
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom % 16);
      int k;
      if (r < 4)       k = K_DESEL;
      else if (r < 9)  k = K_NOP;
      else if (r < 12) k = K_SET;
      else if (r < 15) k = K_CLR;
      else             k = (m_st == 0 || m_st == 3) ? K_READ : K_NOP;
      step(k, 12'($urandom), "R10 random");
    end

    // R8 violation during turn-on wait, R9 sticky, R1 reset clears
    do_reset();
    step(K_SET, 12'h400, "R8 enable");
    step(K_MRS, 12'h000, "R8 mrs in on wait");
    idle_steps(T_ON + 1, "R8 timing unchanged");
    step(K_CLR, 12'h000, "R9 disable");
    idle_steps(T_OFF + 3, "R9 sticky");
    do_reset();
    idle_steps(2, "R1 cleared");
    step(K_SET, 12'h400, "R8 enable");
    idle_steps(T_ON, "R8 drive");
    step(K_READ, 12'h000, "R8 read in drive");
    idle_steps(3, "R8 flag");

    // R8 random traffic with illegal commands anywhere
    do_reset();
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom % 20);
      int k;
      if (r < 4)       k = K_DESEL;
      else if (r < 10) k = K_NOP;
      else if (r < 13) k = K_SET;
      else if (r < 16) k = K_CLR;
      else if (r < 19) k = K_NOP;
      else             k = (i % 2 == 0) ? K_READ : K_MRS;
      step(k, 12'($urandom), "R8 random");
    end
    @(negedge clk);
    check_outputs("final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule